// File: doc/BRIEF.md
# Banked General Register File

This block holds sixteen 32-bit general registers. The low eight of them, the logical registers 0 to 7, exist twice: once in physical bank 0 and once in physical bank 1. A one-bit bank flag decides which copy is seen as registers 0 to 7. Registers 8 to 15 have a single copy that is seen in both settings. The core reads two registers and writes one through its normal ports. Combinational reads return the contents as they were before the next clock edge, so a register being written in the same cycle still reads back its old value.

A fourth port, the alternate port, takes a 3-bit index and reaches the copy of registers 0 to 7 that is currently hidden. It can read it and write it, but only while the privileged-mode input is high. In user mode an alternate access changes nothing and reads back zero. One cycle later an illegal-access flag is raised.

The bank flag is held inside the block. It comes out of reset as 1 and can be loaded by software. An exception or interrupt entry strobe forces it to 1, and this strobe wins over a software load in the same cycle. Instruction decode, the rest of the status register and pipeline forwarding are handled elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: After reset the bank flag `bankSel` reads 1 and `altIllegal` reads 0.
- R2: When `excEntry` is high at a clock edge, `bankSel` is 1 after that edge, even if `bankWrEn` with `bankWrVal`=0 is high in the same cycle.
- R3: When `bankWrEn` is high and `excEntry` is low at a clock edge, `bankSel` takes the value of `bankWrVal` after that edge.
- R4: With `bankSel`=0, logical registers 0 to 7 on the normal ports are physical bank 0, and the alternate port index i reaches bank 1 register i.
- R5: With `bankSel`=1, logical registers 0 to 7 on the normal ports are physical bank 1, and the alternate port index i reaches bank 0 register i.
- R6: Logical registers 8 to 15 hold the same contents whatever the value of `bankSel`.
- R7: In privileged mode (`privMode`=1) an alternate write (`altEn`=1, `altWrite`=1) updates the hidden copy only. The visible register with the same number keeps its value.
- R8: With `privMode`=0, an alternate access changes no register and `altRdData` is 0. `altIllegal` is 1 in the cycle after such an access and 0 in the cycle after any other cycle.
- R9: Normal reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is seen after the edge.
- R10: The two read ports return different addressed registers independently in the same cycle.
- R11: A normal write and a privileged alternate write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| excEntry | input | 1 | Exception/interrupt entry strobe; forces bank flag to 1 |
| bankWrEn | input | 1 | Load the bank flag |
| bankWrVal | input | 1 | Value loaded into the bank flag |
| privMode | input | 1 | 1 = privileged mode; alternate port allowed |
| rdAddrA | input | 4 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 4 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Normal write enable |
| wrAddr | input | 4 | Logical register number for the write |
| wrData | input | 32 | Write data |
| altEn | input | 1 | Alternate port access strobe |
| altWrite | input | 1 | 1 = alternate write, 0 = alternate read |
| altIdx | input | 3 | Register index within the hidden bank |
| altWrData | input | 32 | Alternate write data |
| altRdData | output | 32 | Alternate read data; 0 outside privileged mode |
| altIllegal | output | 1 | User-mode alternate access seen in previous cycle |
| bankSel | output | 1 | Current bank flag |

## Verification
The write-landing assertions assume that `wrData` and `altWrData` stay stable across the edge they are sampled at. The bench changes inputs only at falling edges, so this holds. The alternate/normal disjointness check assumes the bank flag is a clean 0 or 1 and never X after reset. The bench asserts reset before any access. Register contents are never reset, so every register is written before any check reads it.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int NUM_BANKED = 8;
  localparam int NUM_SHARED = 8;
  localparam int NUM_LOGICAL = NUM_BANKED + NUM_SHARED;
  localparam int PHYS_N = 2 * NUM_BANKED + NUM_SHARED;
  localparam int LOG_AW = $clog2(NUM_LOGICAL);
  localparam int ALT_AW = $clog2(NUM_BANKED);
  localparam int PHYS_AW = $clog2(PHYS_N);

  typedef struct packed {
    logic               wrEn;
    logic [PHYS_AW-1:0] wrPhys;
    logic               altWrEn;
    logic [PHYS_AW-1:0] altPhys;
    logic               altRdOk;
    logic [PHYS_AW-1:0] rdPhysA;
    logic [PHYS_AW-1:0] rdPhysB;
  } strobe_t;
endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEntry,
  input  logic              bankWrEn,
  input  logic              bankWrVal,
  input  logic              privMode,
  input  logic [LOG_AW-1:0] rdAddrA,
  input  logic [LOG_AW-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [LOG_AW-1:0] wrAddr,
  input  logic              altEn,
  input  logic              altWrite,
  input  logic [ALT_AW-1:0] altIdx,
  output strobe_t           strb,
  output logic              bankSel,
  output logic              altIllegal
);
  // Physical layout: [0, NUM_BANKED) bank 0, [NUM_BANKED, 2*NUM_BANKED) bank 1, rest shared.
  function automatic logic [PHYS_AW-1:0] mapLogical(input logic [LOG_AW-1:0] a, input logic sel);
    int p;
    if (int'(a) < NUM_BANKED) p = sel ? NUM_BANKED + int'(a) : int'(a);
    else p = 2 * NUM_BANKED + int'(a) - NUM_BANKED;
    return PHYS_AW'(p);
  endfunction

  function automatic logic [PHYS_AW-1:0] mapHidden(input logic [ALT_AW-1:0] i, input logic sel);
    return PHYS_AW'(sel ? int'(i) : NUM_BANKED + int'(i));
  endfunction

  logic altBad;
  assign altBad = altEn && !privMode;

  always_comb begin
    strb.wrEn    = wrEn;
    strb.wrPhys  = mapLogical(wrAddr, bankSel);
    strb.rdPhysA = mapLogical(rdAddrA, bankSel);
    strb.rdPhysB = mapLogical(rdAddrB, bankSel);
    strb.altPhys = mapHidden(altIdx, bankSel);
    strb.altWrEn = altEn && altWrite && privMode;
    strb.altRdOk = privMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel    <= 1'b1;
      altIllegal <= 1'b0;
    end else begin
      if (excEntry)      bankSel <= 1'b1;
      else if (bankWrEn) bankSel <= bankWrVal;
      altIllegal <= altBad;
    end
  end

  // R1: reset leaves the bank flag at 1
  a_r1_reset_bank: assert property (@(posedge clk) !rstN |=> bankSel);
  // R2: exception entry wins over a software load
  a_r2_exc_forces: assert property (@(posedge clk) disable iff (!rstN) excEntry |=> bankSel);
  // R3: software load of the bank flag
  a_r3_bank_load: assert property (@(posedge clk) disable iff (!rstN)
    (bankWrEn && !excEntry) |=> bankSel == $past(bankWrVal));
  // R8: user-mode alternate access raises the flag one cycle later
  a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
    (altEn && !privMode) |=> altIllegal);
  a_r8_no_alt_write: assert property (@(posedge clk) disable iff (!rstN)
    !privMode |-> !strb.altWrEn);
  // R11: alternate target never collides with the normal write target
  a_r11_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.altWrEn) |-> strb.wrPhys != strb.altPhys);
endmodule

// File: rtl/bankrf_datapath.sv
module bankrf_datapath
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] altRdData
);
  logic [DATA_W-1:0] regView [PHYS_N];

  // Contents carry no reset; every entry is its own register.
  for (genvar g = 0; g < PHYS_N; g++) begin : gEntry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.wrPhys == PHYS_AW'(g))         q <= wrData;
      else if (strb.altWrEn && strb.altPhys == PHYS_AW'(g)) q <= altWrData;
    end
    assign regView[g] = q;
  end

  assign rdDataA   = regView[strb.rdPhysA];
  assign rdDataB   = regView[strb.rdPhysB];
  assign altRdData = strb.altRdOk ? regView[strb.altPhys] : '0;

  // R9: a normal write is visible in its target after the edge
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> regView[$past(strb.wrPhys)] == $past(wrData));
  // R11: an alternate write lands too
  a_r11_alt_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.altWrEn |=> regView[$past(strb.altPhys)] == $past(altWrData));
  // R8: alternate read port is blanked outside privileged mode
  a_r8_blank_read: assert property (@(posedge clk) disable iff (!rstN)
    !strb.altRdOk |-> altRdData == '0);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEntry,
  input  logic              bankWrEn,
  input  logic              bankWrVal,
  input  logic              privMode,
  input  logic [LOG_AW-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [LOG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [LOG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altEn,
  input  logic              altWrite,
  input  logic [ALT_AW-1:0] altIdx,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData,
  output logic              altIllegal,
  output logic              bankSel
);
  strobe_t strb;

  bankrf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excEntry(excEntry), .bankWrEn(bankWrEn),
    .bankWrVal(bankWrVal), .privMode(privMode), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .wrEn(wrEn), .wrAddr(wrAddr), .altEn(altEn),
    .altWrite(altWrite), .altIdx(altIdx), .strb(strb), .bankSel(bankSel),
    .altIllegal(altIllegal)
  );

  bankrf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .altWrData(altWrData), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .altRdData(altRdData)
  );
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excEntry = 0, bankWrEn = 0, bankWrVal = 0, privMode = 1;
  logic [3:0] rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [31:0] rdDataA, rdDataB, wrData = 0, altWrData = 0, altRdData;
  logic wrEn = 0, altEn = 0, altWrite = 0, altIllegal, bankSel;
  logic [2:0] altIdx = 0;

  int checks = 0, errors = 0;
  logic [31:0] b0m [8];
  logic [31:0] b1m [8];
  logic [31:0] shm [8];
  logic selM = 1'b1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rstN(rstN), .excEntry(excEntry), .bankWrEn(bankWrEn),
    .bankWrVal(bankWrVal), .privMode(privMode), .rdAddrA(rdAddrA),
    .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .altEn(altEn), .altWrite(altWrite),
    .altIdx(altIdx), .altWrData(altWrData), .altRdData(altRdData),
    .altIllegal(altIllegal), .bankSel(bankSel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expLogical(input int a);
    if (a < 8) return selM ? b1m[a] : b0m[a];
    return shm[a-8];
  endfunction

  function automatic logic [31:0] expHidden(input int i);
    return selM ? b0m[i] : b1m[i];
  endfunction

  task automatic setBank(input logic v);
    @(negedge clk); bankWrEn = 1; bankWrVal = v;
    @(negedge clk); bankWrEn = 0;
    selM = v;
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = 4'(a); wrData = d;
    @(negedge clk); wrEn = 0;
    if (a < 8) begin if (selM) b1m[a] = d; else b0m[a] = d; end
    else shm[a-8] = d;
  endtask

  task automatic rdCheck(input string req, input int a);
    rdAddrA = 4'(a); #1;
    chk(req, rdDataA, expLogical(a));
  endtask

  task automatic altRdCheck(input string req, input int i);
    altEn = 1; altWrite = 0; altIdx = 3'(i); #1;
    chk(req, altRdData, expHidden(i));
    altEn = 0;
  endtask

  task automatic testReset;
    chk("R1 bankSel", 32'(bankSel), 32'd1);
    chk("R1 altIllegal", 32'(altIllegal), 32'd0);
  endtask

  task automatic testBanks;
    for (int i = 0; i < 8; i++) wrReg(i, 32'h1000 + i);
    setBank(1'b0);
    chk("R3 load 0", 32'(bankSel), 32'd0);
    for (int i = 0; i < 8; i++) wrReg(i, 32'h2000 + i);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rdCheck("R4 normal read bank0", i);
      altRdCheck("R4 alt read bank1", i);
    end
    setBank(1'b1);
    chk("R3 load 1", 32'(bankSel), 32'd1);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rdCheck("R5 normal read bank1", i);
      altRdCheck("R5 alt read bank0", i);
    end
  endtask

  task automatic testShared;
    for (int i = 8; i < 16; i++) wrReg(i, 32'h3000 + i);
    @(negedge clk);
    for (int i = 8; i < 16; i++) rdCheck("R6 shared sel1", i);
    setBank(1'b0);
    @(negedge clk);
    for (int i = 8; i < 16; i++) rdCheck("R6 shared sel0", i);
    setBank(1'b1);
  endtask

  task automatic testAltWrite;
    @(negedge clk); privMode = 1; altEn = 1; altWrite = 1; altIdx = 3'd5; altWrData = 32'hAAAA_0005;
    @(negedge clk); altEn = 0; altWrite = 0;
    b0m[5] = 32'hAAAA_0005;
    rdCheck("R7 visible R5 unchanged", 5);
    altRdCheck("R7 hidden R5 updated", 5);
    setBank(1'b0);
    @(negedge clk);
    rdCheck("R7 seen after swap", 5);
    setBank(1'b1);
  endtask

  task automatic testUserAlt;
    @(negedge clk); privMode = 0; altEn = 1; altWrite = 1; altIdx = 3'd2; altWrData = 32'hDEAD_BEEF;
    #1 chk("R8 user alt read zero", altRdData, 32'd0);
    @(negedge clk); altEn = 0; altWrite = 0;
    chk("R8 illegal raised", 32'(altIllegal), 32'd1);
    @(negedge clk);
    chk("R8 illegal cleared", 32'(altIllegal), 32'd0);
    privMode = 1;
    altRdCheck("R8 hidden unchanged", 2);
    rdCheck("R8 visible unchanged", 2);
  endtask

  task automatic testException;
    setBank(1'b0);
    @(negedge clk); excEntry = 1; bankWrEn = 1; bankWrVal = 0;
    @(negedge clk); excEntry = 0; bankWrEn = 0;
    selM = 1;
    chk("R2 exception wins", 32'(bankSel), 32'd1);
  endtask

  task automatic testSameCycle;
    @(negedge clk); wrEn = 1; wrAddr = 4'd9; wrData = 32'h5555_0009; rdAddrA = 4'd9;
    #1 chk("R9 old value same cycle", rdDataA, shm[1]);
    @(negedge clk); wrEn = 0;
    shm[1] = 32'h5555_0009;
    chk("R9 new value after edge", rdDataA, 32'h5555_0009);
  endtask

  task automatic testDualAndConcurrent;
    @(negedge clk); rdAddrA = 4'd3; rdAddrB = 4'd12; #1;
    chk("R10 port A", rdDataA, expLogical(3));
    chk("R10 port B", rdDataB, expLogical(12));
    @(negedge clk);
    wrEn = 1; wrAddr = 4'd4; wrData = 32'h7777_0004;
    altEn = 1; altWrite = 1; altIdx = 3'd4; altWrData = 32'h8888_0004;
    @(negedge clk); wrEn = 0; altEn = 0; altWrite = 0;
    b1m[4] = 32'h7777_0004; b0m[4] = 32'h8888_0004;
    rdCheck("R11 normal write kept", 4);
    altRdCheck("R11 alt write kept", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBanks();
    testShared();
    testAltWrite();
    testUserAlt();
    testException();
    testSameCycle();
    testDualAndConcurrent();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule